// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. A prescaler turns every four input clocks into one count. A position counter then steps the converter through a fixed cycle of three phases. In the first phase, the input is integrated for a fixed number of counts. In the second phase, a reference of the opposite sign is integrated back until the integrator comparator changes state. In the third phase, the integrator is auto-zeroed. During the second phase, a chain of four decade (BCD) stages counts the counts, and that value becomes the conversion result.

At the end of the second phase, the result is moved into an output latch. The latch also holds an overrange flag and the integrated polarity, and a strobe marks the update. The output has no back-pressure. `bcd_valid_o` is high for exactly one clock per cycle, and the sink must accept the value in that clock. The latched value stays stable until the next strobe, so a slow consumer can instead read it at any time between strobes.

The phase outputs and the switch enables drive the analog switch network. The comparator input is asynchronous and passes through a two-flop synchronizer before use. The polarity-swap input exchanges the two reference switches, to suit the board wiring.

Top module: `dslope_seq`

## Requirements
- R1: While and after reset, the block is in auto-zero with `bcd_o`=0, `ovr_o`=0, `sign_o`=0 and `bcd_valid_o`=0. This first auto-zero lasts 1000 counts (4000 clocks), and then integrate begins.
- R2: In every clock, exactly one of `ph_int_o`, `ph_deint_o` and `ph_az_o` is high. The phases follow the order integrate, de-integrate, auto-zero.
- R3: Integrate lasts exactly 1000 counts, which is 4000 clocks.
- R4: De-integrate ends on the first count whose synchronized comparator differs from the polarity captured at the end of integrate. The latched result is the number of counts completed before that count. A comparator change driven 4·N+1 clocks after de-integrate becomes visible lasts 4·(N+1) clocks of de-integrate and latches N.
- R5: If no trip occurs within 2000 counts, de-integrate ends after exactly 2000 counts (8000 clocks). In that case `bcd_o` latches 2000 and `ovr_o` latches 1.
- R6: Every full cycle lasts 4000 counts (16000 clocks). Auto-zero takes the remainder, 3000 − (de-integrate counts).
- R7: `bcd_valid_o` pulses high for one clock once per cycle, in auto-zero after de-integrate ends. `bcd_o`, `ovr_o` and `sign_o` change only in that clock.
- R8: `sign_o` latches the synchronized comparator level captured at the last integrate count.
- R9: `sw_refp_o` = de-integrate AND (captured polarity XOR `pol_swap_i`), and `sw_refn_o` = de-integrate AND NOT that XOR. Both are low outside de-integrate. `sw_sig_o` follows integrate and `sw_az_o` follows auto-zero.
- R10: `bcd_o` holds four BCD digits, each 0 to 9. The ones digit is in [3:0], tens in [7:4], hundreds in [11:8] and thousands in [15:12].
- R11: A trip seen on the 2000th de-integrate count takes priority over overrange. That case latches 1999 with `ovr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Integrator comparator, asynchronous |
| pol_swap_i | input | 1 | Exchanges the two reference switch enables |
| ph_int_o | output | 1 | Signal-integrate phase |
| ph_deint_o | output | 1 | Reference de-integrate phase |
| ph_az_o | output | 1 | Auto-zero phase |
| sw_sig_o | output | 1 | Input switch enable |
| sw_refp_o | output | 1 | Reference switch enable, first sense |
| sw_refn_o | output | 1 | Reference switch enable, second sense |
| sw_az_o | output | 1 | Auto-zero switch enable |
| bcd_o | output | 16 | Latched result, four BCD digits |
| ovr_o | output | 1 | Latched overrange flag |
| sign_o | output | 1 | Latched polarity |
| bcd_valid_o | output | 1 | One-clock strobe for a new latched result |

## Verification
A corrupted position counter shows at the ports as a wrong phase length. The error appears at the next phase boundary, which is at most 12000 clocks away, and it always appears as a cycle length other than 16000 clocks. A wrong captured polarity shows at once as the wrong reference switch in the first de-integrate clock, and later as a wrong `sign_o` at the strobe. A miscounting decade stage or a wrong trip test shows at the next strobe as a latched value that differs from the measured de-integrate length.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_t;
endpackage

// File: rtl/dslope_prescale.sv
module dslope_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || cnt_q == LAST) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      // R3: counts are spaced, never two in adjacent clocks
      p_tick_spaced_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dslope_sync2.sv
module dslope_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dslope_decade_chain.sv
module dslope_decade_chain #(
  parameter int NDIG = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [4*NDIG-1:0] val_o
);
  logic [NDIG-1:0] en;

  genvar g;
  generate
    for (g = 0; g < NDIG; g++) begin : g_stage
      logic [3:0] d_q;

      if (g == 0) begin : g_first
        assign en[g] = inc_i;
      end else begin : g_rest
        assign en[g] = en[g-1] && (val_o[4*(g-1) +: 4] == 4'd9);
      end

      always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)  d_q <= 4'd0;
        else if (en[g])      d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
      end

      assign val_o[4*g +: 4] = d_q;

      // R10: every stage stays a legal decimal digit
      p_digit_range_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        d_q <= 4'd9);
    end
  endgenerate
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int PRESCALE  = 4,
  parameter int INT_CNT   = 1000,
  parameter int DEINT_MAX = 2000,
  parameter int CYCLE_CNT = 4000,
  parameter int NDIG      = 4,
  parameter int SYNC_FF   = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cmp_i,
  input  logic              pol_swap_i,
  output logic              ph_int_o,
  output logic              ph_deint_o,
  output logic              ph_az_o,
  output logic              sw_sig_o,
  output logic              sw_refp_o,
  output logic              sw_refn_o,
  output logic              sw_az_o,
  output logic [4*NDIG-1:0] bcd_o,
  output logic              ovr_o,
  output logic              sign_o,
  output logic              bcd_valid_o
);
  import dslope_pkg::*;

  localparam int POS_W = $clog2(CYCLE_CNT);
  localparam logic [POS_W-1:0] INT_END   = POS_W'(INT_CNT - 1);
  localparam logic [POS_W-1:0] DEINT_END = POS_W'(INT_CNT + DEINT_MAX - 1);
  localparam logic [POS_W-1:0] AZ_START  = POS_W'(INT_CNT + DEINT_MAX);
  localparam logic [POS_W-1:0] CYC_END   = POS_W'(CYCLE_CNT - 1);

  logic tick, cmp_s, trip, chain_clr, chain_inc;
  logic [4*NDIG-1:0] chain_val;

  phase_t            ph_q;
  logic [POS_W-1:0]  pos_q;
  logic              pol_q, pend_q, ovr_pend_q;
  logic [4*NDIG-1:0] bcd_q;
  logic              ovr_q, sign_q, valid_q;

  dslope_prescale #(.DIV(PRESCALE)) u_pre (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick));

  dslope_sync2 #(.STAGES(SYNC_FF)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(cmp_i), .q_o(cmp_s));

  dslope_decade_chain #(.NDIG(NDIG)) u_chain (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(chain_clr), .inc_i(chain_inc),
    .val_o(chain_val));

  assign trip      = (cmp_s != pol_q);
  assign chain_clr = tick && (ph_q == PH_INT) && (pos_q == INT_END);
  assign chain_inc = tick && (ph_q == PH_DEINT) && !trip;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q       <= PH_AZ;
      pos_q      <= AZ_START;
      pol_q      <= 1'b0;
      pend_q     <= 1'b0;
      ovr_pend_q <= 1'b0;
      bcd_q      <= '0;
      ovr_q      <= 1'b0;
      sign_q     <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      if (pend_q) begin
        bcd_q   <= chain_val;
        ovr_q   <= ovr_pend_q;
        sign_q  <= pol_q;
        valid_q <= 1'b1;
      end
      if (tick) begin
        pos_q <= (pos_q == CYC_END) ? '0 : pos_q + 1'b1;
        unique case (ph_q)
          PH_AZ: begin
            if (pos_q == CYC_END) ph_q <= PH_INT;
          end
          PH_INT: begin
            if (pos_q == INT_END) begin
              ph_q  <= PH_DEINT;
              pol_q <= cmp_s;
            end
          end
          PH_DEINT: begin
            if (trip) begin
              ph_q       <= PH_AZ;
              pend_q     <= 1'b1;
              ovr_pend_q <= 1'b0;
            end else if (pos_q == DEINT_END) begin
              ph_q       <= PH_AZ;
              pend_q     <= 1'b1;
              ovr_pend_q <= 1'b1;
            end
          end
          default: ph_q <= PH_AZ;
        endcase
      end
    end
  end

  assign ph_int_o    = (ph_q == PH_INT);
  assign ph_deint_o  = (ph_q == PH_DEINT);
  assign ph_az_o     = (ph_q == PH_AZ);
  assign sw_sig_o    = ph_int_o;
  assign sw_az_o     = ph_az_o;
  assign sw_refp_o   = ph_deint_o && (pol_q ^ pol_swap_i);
  assign sw_refn_o   = ph_deint_o && !(pol_q ^ pol_swap_i);
  assign bcd_o       = bcd_q;
  assign ovr_o       = ovr_q;
  assign sign_o      = sign_q;
  assign bcd_valid_o = valid_q;

  // R2: exactly one phase at a time
  p_phase_onehot_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones({ph_int_o, ph_deint_o, ph_az_o}) == 1);
  // R2: de-integrate is entered only from integrate
  p_deint_after_int_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ph_deint_o) |-> $past(ph_int_o));
  // R2: integrate is entered only from auto-zero
  p_int_after_az_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ph_int_o) |-> $past(ph_az_o));
  // R7: the strobe lasts a single clock
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    bcd_valid_o |=> !bcd_valid_o);
  // R7: latched result holds between strobes
  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !bcd_valid_o |-> $stable(bcd_o) && $stable(ovr_o) && $stable(sign_o));
  // R7: a strobe only appears in auto-zero
  p_valid_in_az_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    bcd_valid_o |-> ph_az_o);
  // R9: reference switches are exclusive and confined to de-integrate
  p_ref_excl_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({sw_refp_o, sw_refn_o}) && ((sw_refp_o || sw_refn_o) == ph_deint_o));
  // R5: an overrange result always reads the full window
  p_ovr_full_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (bcd_valid_o && ovr_o) |-> (bcd_o == (4*NDIG)'(DEINT_MAX / 1000) << 12));
endmodule

// File: tb/dslope_seq_test.sv
`timescale 1ns/1ps
module dslope_seq_test;
  logic clk = 1'b0;
  logic rst, cmp, swap;
  logic ph_int, ph_deint, ph_az, sw_sig, sw_refp, sw_refn, sw_az;
  logic [15:0] bcd;
  logic ovr, sign, bvalid;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dslope_seq uut (
    .clk_i(clk), .rst_i(rst), .cmp_i(cmp), .pol_swap_i(swap),
    .ph_int_o(ph_int), .ph_deint_o(ph_deint), .ph_az_o(ph_az),
    .sw_sig_o(sw_sig), .sw_refp_o(sw_refp), .sw_refn_o(sw_refn), .sw_az_o(sw_az),
    .bcd_o(bcd), .ovr_o(ovr), .sign_o(sign), .bcd_valid_o(bvalid));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int to_bcd(input int n);
    return ((n / 1000) % 10) << 12 | ((n / 100) % 10) << 8 | ((n / 10) % 10) << 4 | (n % 10);
  endfunction

  task automatic t_reset();
    int az_c = 0;
    rst = 1'b1; cmp = 1'b0; swap = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 az", int'(ph_az), 1);
    check("R1 valid", int'(bvalid), 0);
    check("R1 bcd", int'(bcd), 0);
    check("R1 ovr/sign", int'({ovr, sign}), 0);
    rst = 1'b0;
    while (ph_az) begin
      az_c++;
      @(negedge clk);
    end
    check("R1 first auto-zero clocks", az_c, 4000);
    check("R2 integrate follows first auto-zero", int'(ph_int), 1);
  endtask

  // n < 0 means never trip; starts at a negedge in or before integrate
  task automatic run_cycle(input string tag, input logic pol, input logic sw,
                           input int n, input int exp_val, input logic exp_ovr);
    int int_c = 0, de_c = 0, az_c = 0, vcnt = 0, ohbad = 0, swbad = 0;
    int got_bcd = 0, got_ovr = 0, got_sign = 0, refp1 = 0, refn1 = 0;
    while (!ph_int) @(negedge clk);
    cmp = pol; swap = sw;
    while (ph_int) begin
      int_c++;
      if ($countones({ph_int, ph_deint, ph_az}) != 1) ohbad++;
      if (sw_refp || sw_refn || !sw_sig || sw_az) swbad++;
      if (bvalid) vcnt++;
      @(negedge clk);
    end
    while (ph_deint) begin
      de_c++;
      if ($countones({ph_int, ph_deint, ph_az}) != 1) ohbad++;
      if (de_c == 1) begin refp1 = int'(sw_refp); refn1 = int'(sw_refn); end
      if (n >= 0 && de_c == 4 * n + 1) cmp = ~pol;
      if (bvalid) vcnt++;
      @(negedge clk);
    end
    while (ph_az) begin
      az_c++;
      if ($countones({ph_int, ph_deint, ph_az}) != 1) ohbad++;
      if (sw_refp || sw_refn || !sw_az) swbad++;
      if (bvalid) begin
        vcnt++;
        got_bcd = int'(bcd); got_ovr = int'(ovr); got_sign = int'(sign);
      end
      @(negedge clk);
    end
    $display("cycle %s: int=%0d deint=%0d az=%0d", tag, int_c, de_c, az_c);
    check("R2 one-hot phases", ohbad, 0);
    check("R3 integrate clocks", int_c, 4000);
    check(exp_ovr ? "R5 de-integrate clocks" : "R4 de-integrate clocks",
          de_c, exp_ovr ? 8000 : 4 * (n + 1));
    check("R6 full cycle clocks", int_c + de_c + az_c, 16000);
    check("R7 strobes per cycle", vcnt, 1);
    check("R4 R10 latched digits", got_bcd, to_bcd(exp_val));
    check("R5 overrange flag", got_ovr, int'(exp_ovr));
    check("R8 latched polarity", got_sign, int'(pol));
    check("R9 refp in de-integrate", refp1, int'(pol ^ sw));
    check("R9 refn in de-integrate", refn1, int'(!(pol ^ sw)));
    check("R9 switches outside de-integrate", swbad, 0);
    check("R7 result held after cycle", int'(bcd), to_bcd(exp_val));
  endtask

  task automatic t_mid();      run_cycle("mid",   1'b1, 1'b0, 1234, 1234, 1'b0); endtask
  task automatic t_zero();     run_cycle("zero",  1'b0, 1'b1, 0,    0,    1'b0); endtask
  task automatic t_small();    run_cycle("small", 1'b0, 1'b0, 57,   57,   1'b0); endtask
  task automatic t_edge_r11(); run_cycle("edge",  1'b1, 1'b1, 1999, 1999, 1'b0); endtask
  task automatic t_over_r5();  run_cycle("over",  1'b1, 1'b0, -1,   2000, 1'b1); endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mid();
    t_zero();
    t_small();
    t_edge_r11();
    t_over_r5();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule